// File: doc/BRIEF.md
# PAM4 Decision Feedback Equalizer

This block sits in a four-level serial receiver after the digitizer. It accepts one signed sample per symbol and subtracts an estimate of the trailing interference left by the symbols already decided. That estimate is the sum, over the six most recent decisions, of each decision's level times a programmable weight. The corrected sample is clipped to the sample range. It is then compared against three programmable thresholds to pick one of four symbols.

The block presents the 2-bit symbol and the corrected sample one clock after the input. The corrected sample is the one the timing-recovery logic consumes. Each new decision enters the history in the same edge that registers it, so the very next sample is already corrected by it.

A training controller loads the weights and thresholds through a small write port. It can load an amplitude value that places the thresholds symmetrically, or it can set each threshold on its own.

Top module: `pam4_dfe`

## Requirements
- R1: Reset clears the outputs to zero and clears all six history entries to the zero level. It also clears every weight to zero and sets the thresholds to -32, 0 and +32 (-2A, 0 and +2A with default A = 16).
- R2: A sample presented with `in_valid` high produces `out_valid` high, `out_sym` and `out_eq` on the next clock. A cycle with `in_valid` low drives `out_valid` low and leaves `out_sym`, `out_eq` and the history unchanged.
- R3: `out_eq` equals the input sample minus the sum over k = 0..5 of weight k times history level k. History entry 0 is the most recent decision and entry 5 the oldest. Symbol codes map to levels as 00 = -3, 01 = -1, 11 = +1 and 10 = +3.
- R4: With back-to-back valid samples, the decision on sample n is already history entry 0 when sample n+1 is corrected. There is no bubble.
- R5: Before slicing, the corrected value saturates to the signed 8-bit range [-128, +127].
- R6: The slicer outputs 10 when the value is at or above the upper threshold, 11 when it is at or above the middle one, 01 when it is at or above the lower one, and 00 otherwise. A value equal to a threshold takes the higher symbol.
- R7: A write to address 6 with amplitude A (0..63) sets the thresholds to -2A, 0 and +2A.
- R8: Writes to addresses 7, 8 and 9 set the lower, middle and upper threshold individually (signed 8-bit).
- R9: Writes to addresses 0..5 set weight k = address (signed 8-bit). Writes to addresses 10..15 change no weight and no threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_sample | input | 8 | Signed digitized sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (0..5 weights, 6 amplitude, 7..9 thresholds) |
| cfg_data | input | 8 | Configuration write data |
| out_valid | output | 1 | Decision present this cycle |
| out_sym | output | 2 | Gray-coded symbol decision |
| out_eq | output | 8 | Corrected, saturated sample for timing recovery |

## Verification
The hardest state to reach from the ports is a correction large enough to push the corrected value past either rail. It takes several weights programmed near their limits and a history that holds many same-sign decisions at once. The bench loads six large weights and then streams full-scale samples back to back, so the history alternates and piles up extreme levels, and it compares every clipped result with a reference model. The one-clock decision loop is shown with a single large first weight. There, the sign of each corrected sample flips because of the decision made in the cycle just before it.

// File: rtl/pam4_dfe_pkg.sv
package pam4_dfe_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        SYM_M3 = 2'b00,
        SYM_M1 = 2'b01,
        SYM_P1 = 2'b11,
        SYM_P3 = 2'b10
    } sym_e;

    // Gray symbol code to signed decision level
    function automatic logic signed [LVL_W-1:0] sym_level(input logic [1:0] code);
        logic signed [LVL_W-1:0] lvl;
        case (code)
            2'b00:   lvl = -3'sd3;
            2'b01:   lvl = -3'sd1;
            2'b11:   lvl = 3'sd1;
            default: lvl = 3'sd3;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/pam4_dfe_cfg.sv
module pam4_dfe_cfg #(
    parameter int NTAPS    = 6,
    parameter int COEF_W   = 8,
    parameter int SAMPLE_W = 8,
    parameter int ADDR_W   = 4,
    parameter int CFG_W    = 8,
    parameter int DEF_AMP  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [CFG_W-1:0]              cfg_data,
    output logic [NTAPS-1:0][COEF_W-1:0]  taps,
    output logic signed [SAMPLE_W-1:0]    thr_lo,
    output logic signed [SAMPLE_W-1:0]    thr_mid,
    output logic signed [SAMPLE_W-1:0]    thr_hi
);

    localparam int ADR_AMP    = NTAPS;
    localparam int ADR_THR_LO = NTAPS + 1;
    localparam int ADR_THR_MD = NTAPS + 2;
    localparam int ADR_THR_HI = NTAPS + 3;
    localparam logic [SAMPLE_W-1:0] DEF_HI = SAMPLE_W'(2 * DEF_AMP);
    localparam logic [SAMPLE_W-1:0] DEF_LO = SAMPLE_W'(-2 * DEF_AMP);

    typedef struct packed {
        logic [NTAPS-1:0][COEF_W-1:0] taps;
        logic [SAMPLE_W-1:0]          lo;
        logic [SAMPLE_W-1:0]          mid;
        logic [SAMPLE_W-1:0]          hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [SAMPLE_W-1:0] twice_amp;

    always_comb begin
        twice_amp = {cfg_data[SAMPLE_W-2:0], 1'b0};
        cfg_d     = cfg_q;
        if (cfg_we) begin
            for (int k = 0; k < NTAPS; k++) begin
                if (cfg_addr == ADDR_W'(k)) begin
                    cfg_d.taps[k] = cfg_data[COEF_W-1:0];
                end
            end
            if (cfg_addr == ADDR_W'(ADR_AMP)) begin
                cfg_d.hi  = twice_amp;
                cfg_d.mid = '0;
                cfg_d.lo  = SAMPLE_W'(-twice_amp);
            end
            if (cfg_addr == ADDR_W'(ADR_THR_LO)) cfg_d.lo  = cfg_data[SAMPLE_W-1:0];
            if (cfg_addr == ADDR_W'(ADR_THR_MD)) cfg_d.mid = cfg_data[SAMPLE_W-1:0];
            if (cfg_addr == ADDR_W'(ADR_THR_HI)) cfg_d.hi  = cfg_data[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.taps <= '0;
            cfg_q.lo   <= DEF_LO;
            cfg_q.mid  <= '0;
            cfg_q.hi   <= DEF_HI;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign taps    = cfg_q.taps;
    assign thr_lo  = $signed(cfg_q.lo);
    assign thr_mid = $signed(cfg_q.mid);
    assign thr_hi  = $signed(cfg_q.hi);

    AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > ADDR_W'(ADR_THR_HI)) |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/pam4_dfe_fir.sv
module pam4_dfe_fir
    import pam4_dfe_pkg::*;
#(
    parameter int NTAPS  = 6,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 14
) (
    input  logic [NTAPS-1:0][LVL_W-1:0]  hist,
    input  logic [NTAPS-1:0][COEF_W-1:0] taps,
    output logic signed [ACC_W-1:0]      isi
);

    localparam int PROD_W = COEF_W + LVL_W;

    logic signed [PROD_W-1:0] prod [NTAPS];

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            assign prod[k] = PROD_W'($signed(taps[k])) * PROD_W'($signed(hist[k]));
        end
    endgenerate

    always_comb begin
        isi = '0;
        for (int k = 0; k < NTAPS; k++) begin
            isi = isi + ACC_W'(prod[k]);
        end
    end

endmodule

// File: rtl/pam4_dfe_slicer.sv
module pam4_dfe_slicer
    import pam4_dfe_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 14
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [ACC_W-1:0]    isi,
    input  logic signed [SAMPLE_W-1:0] thr_lo,
    input  logic signed [SAMPLE_W-1:0] thr_mid,
    input  logic signed [SAMPLE_W-1:0] thr_hi,
    output logic signed [SAMPLE_W-1:0] eq_sat,
    output logic [1:0]                 sym,
    output logic [LVL_W-1:0]           lvl
);

    localparam int DIFF_W = ((ACC_W > SAMPLE_W) ? ACC_W : SAMPLE_W) + 1;
    localparam logic signed [DIFF_W-1:0] POS_RAIL = DIFF_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] NEG_RAIL = DIFF_W'(-(2 ** (SAMPLE_W - 1)));

    logic signed [DIFF_W-1:0] diff;

    always_comb begin
        diff = DIFF_W'(sample) - DIFF_W'(isi);
        if (diff > POS_RAIL) begin
            eq_sat = POS_RAIL[SAMPLE_W-1:0];
        end else if (diff < NEG_RAIL) begin
            eq_sat = NEG_RAIL[SAMPLE_W-1:0];
        end else begin
            eq_sat = diff[SAMPLE_W-1:0];
        end

        if (eq_sat >= thr_hi) begin
            sym = SYM_P3;
        end else if (eq_sat >= thr_mid) begin
            sym = SYM_P1;
        end else if (eq_sat >= thr_lo) begin
            sym = SYM_M1;
        end else begin
            sym = SYM_M3;
        end
        lvl = sym_level(sym);
    end

endmodule

// File: rtl/pam4_dfe.sv
module pam4_dfe
    import pam4_dfe_pkg::*;
#(
    parameter int NTAPS    = 6,
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int DEF_AMP  = 16,
    localparam int CFG_W   = (COEF_W > SAMPLE_W) ? COEF_W : SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [CFG_W-1:0]           cfg_data,
    output logic                       out_valid,
    output logic [1:0]                 out_sym,
    output logic signed [SAMPLE_W-1:0] out_eq
);

    localparam int PROD_W = COEF_W + LVL_W;
    localparam int ACC_W  = PROD_W + $clog2(NTAPS);

    typedef struct packed {
        logic [NTAPS-1:0][LVL_W-1:0] hist;
        logic                        vld;
        logic [1:0]                  sym;
        logic [SAMPLE_W-1:0]         eq;
    } state_t;

    state_t st_d, st_q;

    logic [NTAPS-1:0][COEF_W-1:0] taps;
    logic signed [SAMPLE_W-1:0]   thr_lo, thr_mid, thr_hi;
    logic signed [ACC_W-1:0]      isi;
    logic signed [SAMPLE_W-1:0]   eq_sat;
    logic [1:0]                   new_sym;
    logic [LVL_W-1:0]             new_lvl;

    pam4_dfe_cfg #(
        .NTAPS(NTAPS), .COEF_W(COEF_W), .SAMPLE_W(SAMPLE_W),
        .ADDR_W(ADDR_W), .CFG_W(CFG_W), .DEF_AMP(DEF_AMP)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .taps(taps), .thr_lo(thr_lo),
        .thr_mid(thr_mid), .thr_hi(thr_hi)
    );

    pam4_dfe_fir #(
        .NTAPS(NTAPS), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) u_fir (
        .hist(st_q.hist), .taps(taps), .isi(isi)
    );

    pam4_dfe_slicer #(
        .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)
    ) u_slicer (
        .sample(in_sample), .isi(isi), .thr_lo(thr_lo), .thr_mid(thr_mid),
        .thr_hi(thr_hi), .eq_sat(eq_sat), .sym(new_sym), .lvl(new_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.hist = {st_q.hist[NTAPS-2:0], new_lvl};
            st_d.vld  = 1'b1;
            st_d.sym  = new_sym;
            st_d.eq   = eq_sat;
        end else begin
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_sym   = st_q.sym;
    assign out_eq    = $signed(st_q.eq);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sym) && $stable(out_eq) && $stable(st_q.hist))); // R2

    AST_HIST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(st_q.hist[0]) == sym_level(out_sym))); // R4

    AST_TOP_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_eq >= $past(thr_hi)) == (out_sym == SYM_P3))); // R6

endmodule

// File: tb/pam4_dfe_tb.sv
module pam4_dfe_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_addr = '0;
    logic [7:0]        cfg_data = '0;
    logic              out_valid;
    logic [1:0]        out_sym;
    logic signed [7:0] out_eq;

    int tests_run = 0;
    int tests_fail = 0;
    bit finished = 1'b0;

    int m_coef [6];
    int m_hist [6];
    int m_lo, m_mid, m_hi;

    always #2.5 clk = ~clk;

    pam4_dfe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_sym(out_sym), .out_eq(out_eq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int lvl_to_code(input int l);
        case (l)
            -3: return 0;
            -1: return 1;
            1: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin m_coef[k] = 0; m_hist[k] = 0; end
        m_lo = -32; m_mid = 0; m_hi = 32;
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 6) m_coef[addr] = data;
        else if (addr == 6) begin m_hi = 2 * data; m_mid = 0; m_lo = -2 * data; end
        else if (addr == 7) m_lo = data;
        else if (addr == 8) m_mid = data;
        else if (addr == 9) m_hi = data;
    endtask

    task automatic send(input int s, input string req);
        int acc, e, l;
        in_valid = 1'b1; in_sample = 8'(s);
        acc = 0;
        for (int k = 0; k < 6; k++) acc += m_coef[k] * m_hist[k];
        e = sat8(s - acc);
        if (e >= m_hi) l = 3;
        else if (e >= m_mid) l = 1;
        else if (e >= m_lo) l = -1;
        else l = -3;
        @(negedge clk);
        check(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
        check(int'(out_eq) == e, req, "out_eq", int'(out_eq), e);
        check(int'(out_sym) == lvl_to_code(l), req, "out_sym", int'(out_sym), lvl_to_code(l));
        for (int k = 5; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = l;
    endtask

    task automatic idle(input int n);
        logic [1:0] sym0;
        logic signed [7:0] eq0;
        sym0 = out_sym; eq0 = out_eq;
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R2", "idle out_valid", int'(out_valid), 0);
            check(out_sym == sym0, "R2", "idle out_sym", int'(out_sym), int'(sym0));
            check(out_eq == eq0, "R2", "idle out_eq", int'(out_eq), int'(eq0));
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        check(out_sym == 2'b00, "R1", "reset out_sym", int'(out_sym), 0);
        check(out_eq == 8'sd0, "R1", "reset out_eq", int'(out_eq), 0);
    endtask

    task automatic t_slicer();
        do_reset();
        send(31, "R6"); send(32, "R6"); send(0, "R6"); send(-1, "R6");
        send(-32, "R6"); send(-33, "R6"); send(127, "R1"); send(-128, "R1");
        idle(1);
    endtask

    task automatic t_taps();
        int samples [12] = '{60, -70, 10, -5, 90, -100, 30, 0, -40, 45, -20, 80};
        do_reset();
        cfg_write(0, 12); cfg_write(1, -7); cfg_write(2, 5);
        cfg_write(3, 3); cfg_write(4, -2); cfg_write(5, 6);
        foreach (samples[i]) send(samples[i], "R3");
        idle(1);
    endtask

    task automatic t_first_tap();
        do_reset();
        cfg_write(0, 40);
        send(100, "R4"); send(100, "R4"); send(10, "R4"); send(-20, "R4");
        idle(1);
    endtask

    task automatic t_sat();
        do_reset();
        for (int k = 0; k < 6; k++) cfg_write(k, 60);
        for (int i = 0; i < 4; i++) send(127, "R5");
        for (int i = 0; i < 4; i++) send(-128, "R5");
        send(127, "R5"); send(-128, "R5");
        idle(1);
    endtask

    task automatic t_idle();
        do_reset();
        cfg_write(0, 20); cfg_write(2, -10);
        send(70, "R2"); send(-50, "R2");
        idle(3);
        send(5, "R2"); send(-5, "R2");
        idle(1);
    endtask

    task automatic t_amp();
        do_reset();
        cfg_write(6, 20);
        send(39, "R7"); send(40, "R7"); send(-40, "R7"); send(-41, "R7");
        idle(1);
    endtask

    task automatic t_thr();
        do_reset();
        cfg_write(7, -60); cfg_write(8, 10); cfg_write(9, 70);
        send(9, "R8"); send(10, "R8"); send(69, "R8"); send(70, "R8");
        send(-60, "R8"); send(-61, "R8");
        idle(1);
    endtask

    task automatic t_ignored();
        do_reset();
        cfg_write(1, 9);
        cfg_write(10, 100); cfg_write(12, -100); cfg_write(15, 55);
        send(31, "R9"); send(32, "R9"); send(-33, "R9"); send(40, "R9");
        idle(1);
    endtask

    task automatic t_reset_clears_history();
        do_reset();
        cfg_write(0, 50);
        send(100, "R1"); send(100, "R1");
        do_reset();
        cfg_write(0, 50);
        send(0, "R1");
        idle(1);
    endtask

    initial begin
        t_reset();
        t_slicer();
        t_taps();
        t_first_tap();
        t_sat();
        t_idle();
        t_amp();
        t_thr();
        t_ignored();
        t_reset_clears_history();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests_run++;
            tests_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
            $finish;
        end
    end

endmodule